// File: doc/BRIEF.md
# Discharge Overcurrent Guard

This block supervises one or more discharge overcurrent channels of a battery protector. Each channel receives a comparator result that is already evaluated against its programmed shunt-voltage limit (a code covering 4 mV to 200 mV in 2 mV steps, decoded elsewhere), an enable, and a delay-expired signal from an external detection-delay timer. From these it keeps a three-state machine: normal, alerted (over the limit, delay running) and faulted (delay served). While alerted the channel asks the external timer to run; when the timer reports expiry with the current still high, the channel faults, drops its alert, and emits a one-cycle trip pulse that a shared latch counter can count.

A faulted channel leaves the fault either by time or by host command. Time-based recovery counts one-second ticks while the current stays at or below the limit, and any over-limit sample restarts the count. A recovery setting of zero turns time-based recovery off, so only a host recovery strobe carrying the channel's select bit clears the fault. The discharge switch off-request combines the channels whose autonomous-off bit is set with a latched-off input from the latch counter, so a recovered channel cannot reopen a latched switch. Two instances with independent settings is the default configuration.

Top module: `discharge_overcurrent_guard`

## Requirements
- R1: After reset every channel is normal: alert, fault, trip and delay-run outputs are 0, and the switch off-request is 0 while latched_off is 0.
- R2: An enabled normal channel that samples over_thr=1 at a clock edge shows alert=1 and dly_run=1 after that edge; if it samples over_thr=0 while alerted, alert and dly_run return to 0 after that edge and fault stays 0.
- R3: An alerted channel that samples over_thr=1 and delay_done=1 at the same edge shows fault=1, alert=0 and trip=1 after that edge; trip is 0 again one cycle later while fault stays 1.
- R4: dsg_off is 1 whenever some channel has fault=1 and its auto_off bit is 1; a faulted channel whose auto_off bit is 0 does not raise dsg_off.
- R5: With a non-zero recovery setting N (channel c uses recov_time bits [8c+7:8c]), a faulted channel clears fault at the edge that samples its N-th sec_tick taken while over_thr=0.
- R6: Any over_thr=1 sample while faulted restarts the recovery count from zero, so N further qualifying ticks are then needed.
- R7: With a recovery setting of 0, sec_tick never clears the fault; a host_recov strobe clears the fault at the edge it is sampled only for channels whose host_recov_sel bit is 1, and other channels are unaffected.
- R8: dsg_off is 1 whenever latched_off is 1, including after every channel has recovered.
- R9: A channel sampled with ch_en=0 has alert=0 and fault=0 after that edge and ignores over_thr while disabled.
- R10: Channels are independent: a fault, alert or recovery on one channel leaves the other channel's outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse per second |
| over_thr | input | NCH | Per-channel comparator result, 1 = above limit |
| ch_en | input | NCH | Per-channel protection enable |
| delay_done | input | NCH | Per-channel detection delay expired |
| auto_off | input | NCH | Per-channel autonomous switch-off enable |
| recov_time | input | NCH*RECOV_W | Per-channel recovery time in seconds, 0 = host only |
| host_recov | input | 1 | Host recovery command strobe |
| host_recov_sel | input | NCH | Channels the host command applies to |
| latched_off | input | 1 | Switch latched off by the latch counter |
| alert | output | NCH | Over limit, delay running |
| fault | output | NCH | Fault status |
| trip | output | NCH | One-cycle pulse on fault entry |
| dly_run | output | NCH | Run request to the external delay timer |
| dsg_off | output | 1 | Request to turn the discharge switch off |

## Verification
The hardest situation to reach is a recovery window that is broken part-way: the channel must be faulted, collect some but not all of its seconds, see a single over-limit sample, and then need the full count again. The stimulus faults a channel through its alert phase, issues one-cycle tick pulses one at a time, inserts an isolated over_thr cycle between ticks, and checks the fault after each tick so the edge on which it clears is pinned exactly. The zero-setting case is reached the same way, with host strobes aimed first at the wrong channel.

// File: rtl/dog_pkg.sv
package dog_pkg;

  // Widest recovery setting the arithmetic helper accepts.
  localparam int unsigned CALC_W = 16;

  typedef enum logic [1:0] {
    ST_NORMAL = 2'd0,
    ST_ALERT  = 2'd1,
    ST_FAULT  = 2'd2
  } guard_state_e;

  // True when a recovery count that has just reached cnt_next satisfies
  // a non-zero setting. A zero setting never satisfies.
  function automatic logic recov_reached(input logic [CALC_W-1:0] cnt_next,
                                         input logic [CALC_W-1:0] setting);
    return (setting != '0) && (cnt_next >= setting);
  endfunction

endpackage

// File: rtl/dog_recov_timer.sv
module dog_recov_timer #(
  parameter int unsigned RECOV_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               over,
  input  logic               tick,
  input  logic [RECOV_W-1:0] setting,
  output logic               done,
  output logic [RECOV_W-1:0] count
);
  import dog_pkg::*;

  localparam logic [RECOV_W-1:0] CNT_MAX = '1;
  localparam int unsigned PAD_W = CALC_W - RECOV_W;

  logic [RECOV_W-1:0] cnt_q;
  logic [RECOV_W-1:0] cnt_inc;
  logic               counting;

  assign cnt_inc  = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
  assign counting = run && !over && tick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || over) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= cnt_inc;
    end
  end

  assign done  = counting &&
                 recov_reached({{PAD_W{1'b0}}, cnt_inc}, {{PAD_W{1'b0}}, setting});
  assign count = cnt_q;

  // R6: a sample above the limit inside the window leaves a cleared count
  a_r6_count_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (run && over) |=> (count == '0));

endmodule

// File: rtl/dog_channel.sv
module dog_channel #(
  parameter int unsigned RECOV_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               over,
  input  logic               delay_done,
  input  logic               tick,
  input  logic [RECOV_W-1:0] setting,
  input  logic               host_hit,
  input  logic               auto_off,
  output logic               alert,
  output logic               fault,
  output logic               trip,
  output logic               dly_run,
  output logic               off_req
);
  import dog_pkg::*;

  guard_state_e       st_q, st_d;
  logic               trip_q;
  logic               rec_done;
  logic               rec_run;
  logic               enter_fault;
  logic               leave_fault;
  logic [RECOV_W-1:0] rec_count;

  assign rec_run = (st_q == ST_FAULT);

  dog_recov_timer #(.RECOV_W(RECOV_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (rec_run),
    .over    (over),
    .tick    (tick),
    .setting (setting),
    .done    (rec_done),
    .count   (rec_count)
  );

  always_comb begin
    st_d = st_q;
    if (!en) begin
      st_d = ST_NORMAL;
    end else begin
      unique case (st_q)
        ST_NORMAL: if (over) st_d = ST_ALERT;
        ST_ALERT: begin
          if (!over)           st_d = ST_NORMAL;
          else if (delay_done) st_d = ST_FAULT;
        end
        ST_FAULT: if (host_hit || rec_done) st_d = ST_NORMAL;
        default: st_d = ST_NORMAL;
      endcase
    end
  end

  assign enter_fault = (st_q == ST_ALERT) && (st_d == ST_FAULT);
  assign leave_fault = (st_q == ST_FAULT) && (st_d != ST_FAULT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_NORMAL;
      trip_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      trip_q <= enter_fault;
    end
  end

  assign alert   = (st_q == ST_ALERT);
  assign fault   = (st_q == ST_FAULT);
  assign trip    = trip_q;
  assign dly_run = alert;
  assign off_req = fault && auto_off;

  // R2: alert and fault are exclusive
  a_r2_alert_fault_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(alert && fault));

  // R3: trip lasts exactly one cycle
  a_r3_trip_single: assert property (@(posedge clk) disable iff (!rst_n)
    trip |=> !trip);

  // R3: trip accompanies the first faulted cycle with alert already clear
  a_r3_trip_with_fault: assert property (@(posedge clk) disable iff (!rst_n)
    trip |-> (fault && !alert));

  // R7: with a zero setting, only the host or a disable ends a fault
  a_r7_zero_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && en && (setting == '0) && !host_hit) |=> fault);

  // R5: a fault only ends through the timer, the host, or a disable
  a_r5_exit_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && en && !host_hit && !rec_done) |=> fault);

  // R9: a disabled channel shows no flags on the next cycle
  a_r9_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!alert && !fault));

  // R6: leaving by time needs at least one counted second
  a_r6_exit_needs_count: assert property (@(posedge clk) disable iff (!rst_n)
    (leave_fault && rec_done && !host_hit) |-> ((rec_count + 1'b1) >= setting));

endmodule

// File: rtl/discharge_overcurrent_guard.sv
module discharge_overcurrent_guard #(
  parameter int unsigned NCH     = 2,
  parameter int unsigned RECOV_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sec_tick,
  input  logic [NCH-1:0]         over_thr,
  input  logic [NCH-1:0]         ch_en,
  input  logic [NCH-1:0]         delay_done,
  input  logic [NCH-1:0]         auto_off,
  input  logic [NCH*RECOV_W-1:0] recov_time,
  input  logic                   host_recov,
  input  logic [NCH-1:0]         host_recov_sel,
  input  logic                   latched_off,
  output logic [NCH-1:0]         alert,
  output logic [NCH-1:0]         fault,
  output logic [NCH-1:0]         trip,
  output logic [NCH-1:0]         dly_run,
  output logic                   dsg_off
);

  logic [NCH-1:0] ch_off;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dog_channel #(.RECOV_W(RECOV_W)) u_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (ch_en[c]),
      .over       (over_thr[c]),
      .delay_done (delay_done[c]),
      .tick       (sec_tick),
      .setting    (recov_time[c*RECOV_W +: RECOV_W]),
      .host_hit   (host_recov && host_recov_sel[c]),
      .auto_off   (auto_off[c]),
      .alert      (alert[c]),
      .fault      (fault[c]),
      .trip       (trip[c]),
      .dly_run    (dly_run[c]),
      .off_req    (ch_off[c])
    );
  end

  assign dsg_off = (|ch_off) || latched_off;

  // R1: nothing is reported in the first cycle after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (alert == '0 && fault == '0 && trip == '0));

  // R4: a faulted channel with its autonomous bit set keeps the switch off
  a_r4_fault_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
    ((fault & auto_off) != '0) |-> dsg_off);

endmodule

// File: tb/test_discharge_overcurrent_guard.sv
`timescale 1ns/100ps
module test_discharge_overcurrent_guard;
  localparam int NCH = 2;
  localparam int RW  = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            sec_tick = 1'b0;
  logic [NCH-1:0]  over_thr = '0;
  logic [NCH-1:0]  ch_en = '0;
  logic [NCH-1:0]  delay_done = '0;
  logic [NCH-1:0]  auto_off = '0;
  logic [NCH*RW-1:0] recov_time = '0;
  logic            host_recov = 1'b0;
  logic [NCH-1:0]  host_recov_sel = '0;
  logic            latched_off = 1'b0;
  logic [NCH-1:0]  alert, fault, trip, dly_run;
  logic            dsg_off;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  discharge_overcurrent_guard #(.NCH(NCH), .RECOV_W(RW)) i_discharge_overcurrent_guard (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .over_thr(over_thr),
    .ch_en(ch_en), .delay_done(delay_done), .auto_off(auto_off),
    .recov_time(recov_time), .host_recov(host_recov),
    .host_recov_sel(host_recov_sel), .latched_off(latched_off),
    .alert(alert), .fault(fault), .trip(trip), .dly_run(dly_run),
    .dsg_off(dsg_off)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive channel c through alert into fault.
  task automatic make_fault(input int c);
    over_thr[c] = 1'b1;
    step();
    delay_done[c] = 1'b1;
    step();
    delay_done[c] = 1'b0;
    over_thr[c] = 1'b0;
  endtask

  task automatic one_tick();
    sec_tick = 1'b1;
    step();
    sec_tick = 1'b0;
    step();
  endtask

  task automatic clear_all();
    host_recov = 1'b1;
    host_recov_sel = '1;
    step();
    host_recov = 1'b0;
    host_recov_sel = '0;
    over_thr = '0;
    delay_done = '0;
    step();
  endtask

  task automatic t_reset();
    check("R1 alert", alert, 0);
    check("R1 fault", fault, 0);
    check("R1 trip", trip, 0);
    check("R1 dly_run", dly_run, 0);
    check("R1 dsg_off", dsg_off, 0);
  endtask

  task automatic t_alert_drop();
    over_thr[0] = 1'b1;
    step();
    check("R2 alert set", alert, 2'b01);
    check("R2 dly_run", dly_run, 2'b01);
    over_thr[0] = 1'b0;
    step();
    check("R2 alert clear", alert, 0);
    check("R2 dly_run clear", dly_run, 0);
    check("R2 no fault", fault, 0);
  endtask

  task automatic t_trip();
    auto_off = 2'b01;
    over_thr[0] = 1'b1;
    step();
    delay_done[0] = 1'b1;
    step();
    delay_done[0] = 1'b0;
    check("R3 fault set", fault, 2'b01);
    check("R3 alert cleared", alert, 0);
    check("R3 trip pulse", trip, 2'b01);
    check("R4 auto off", dsg_off, 1);
    step();
    check("R3 trip ends", trip, 0);
    check("R3 fault held", fault, 2'b01);
    over_thr[0] = 1'b0;
    clear_all();
    auto_off = '0;
  endtask

  task automatic t_no_auto();
    auto_off = 2'b01;
    make_fault(1);
    check("R4 ch1 faulted", fault, 2'b10);
    check("R4 no auto bit", dsg_off, 0);
    clear_all();
    auto_off = '0;
  endtask

  task automatic t_time_recov();
    recov_time = {8'd0, 8'd3};
    auto_off = 2'b01;
    make_fault(0);
    one_tick();
    one_tick();
    check("R5 before N", fault, 2'b01);
    one_tick();
    check("R5 cleared at N", fault, 0);
    check("R5 switch released", dsg_off, 0);
    auto_off = '0;
  endtask

  task automatic t_over_restart();
    recov_time = {8'd0, 8'd3};
    make_fault(0);
    one_tick();
    one_tick();
    over_thr[0] = 1'b1;
    step();
    over_thr[0] = 1'b0;
    step();
    check("R6 still faulted after over", fault, 2'b01);
    one_tick();
    one_tick();
    check("R6 count restarted", fault, 2'b01);
    one_tick();
    check("R6 cleared after full N", fault, 0);
  endtask

  task automatic t_zero_setting();
    recov_time = '0;
    make_fault(0);
    for (int i = 0; i < 6; i++) one_tick();
    check("R7 ticks ignored", fault, 2'b01);
    host_recov = 1'b1;
    host_recov_sel = 2'b10;
    step();
    host_recov = 1'b0;
    host_recov_sel = '0;
    check("R7 wrong select ignored", fault, 2'b01);
    host_recov = 1'b1;
    host_recov_sel = 2'b01;
    step();
    host_recov = 1'b0;
    host_recov_sel = '0;
    check("R7 host clears", fault, 0);
  endtask

  task automatic t_latched();
    latched_off = 1'b1;
    #1;
    check("R8 latched forces off", dsg_off, 1);
    recov_time = {8'd0, 8'd1};
    auto_off = 2'b01;
    make_fault(0);
    one_tick();
    check("R8 recovered", fault, 0);
    check("R8 still off", dsg_off, 1);
    latched_off = 1'b0;
    auto_off = '0;
    #1;
    check("R8 release", dsg_off, 0);
  endtask

  task automatic t_disable();
    recov_time = '0;
    make_fault(0);
    ch_en[0] = 1'b0;
    step();
    check("R9 fault cleared", fault, 0);
    over_thr[0] = 1'b1;
    step();
    step();
    check("R9 over ignored alert", alert, 0);
    check("R9 over ignored fault", fault, 0);
    over_thr[0] = 1'b0;
    ch_en[0] = 1'b1;
    step();
  endtask

  task automatic t_indep();
    recov_time = '0;
    make_fault(0);
    step();
    check("R10 ch1 untouched", {alert[1], fault[1], trip[1]}, 0);
    over_thr[1] = 1'b1;
    step();
    check("R10 ch1 alert", alert, 2'b10);
    check("R10 ch0 fault kept", fault, 2'b01);
    host_recov = 1'b1;
    host_recov_sel = 2'b01;
    step();
    host_recov = 1'b0;
    host_recov_sel = '0;
    check("R10 ch0 cleared", fault, 0);
    check("R10 ch1 alert kept", alert, 2'b10);
    over_thr[1] = 1'b0;
    step();
  endtask

  initial begin
    step();
    step();
    rst_n = 1'b1;
    step();
    t_reset();
    ch_en = '1;
    t_alert_drop();
    t_trip();
    t_no_auto();
    t_time_recov();
    t_over_restart();
    t_zero_setting();
    t_latched();
    t_disable();
    t_indep();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule